// File: doc/BRIEF.md
# CCD Quadrant Readout Clock Sequencer

This block produces the logic-level clock waveforms that move charge through one quadrant of a full-frame CCD. It drives two vertical phases, two horizontal phases, a last-horizontal phase and the output reset gate. It also generates the clamp and sample strobes for the downstream correlated-double-sampling ADC. Level shifters and analog drivers sit outside the block.

A start pulse launches a complete frame cycle. First a flush pass empties the array, using single-line transfers and full-length shifts. An exposure window follows, with the vertical phases parked low, for a programmable number of system cycles. Last comes the readout pass, in either full-resolution mode or 3x3 binned mode. In binned mode, three rows are summed into the horizontal register, and three horizontal packets are summed on the output node per reset. All intervals are counted in cycles of a 100 MHz system clock. By default a pixel period is 5 cycles, the vertical high time is 1000 cycles and the horizontal setup time is 500 cycles.

Top module: `ccd_seq_top`

## Requirements
- R1: After reset, and whenever idle: busy=0, v1=v2=0, h1=hl=1, h2=0, and rg, clamp, sample, line_start and frame_end are all 0.
- R2: A start pulse seen while idle begins a frame; busy rises on the next cycle. The mode (`bin_mode`: 0 = full resolution, 1 = 3x3 binned) and `int_len` are captured at that start. A start pulse, a mode change or a length change during a frame has no effect on any output.
- R3: The flush pass clocks LINES lines. Each line has one vertical transfer, the setup wait and PIX_PER_LINE pixel shifts. rg pulses once per pixel, and clamp, sample and line_start stay 0.
- R4: Integration lasts max(int_len,1) cycles. During it v1=v2=0 and h1=hl=1.
- R5: A vertical transfer lasts VHIGH_CYC cycles in four equal quarters: v1 only, then v1 and v2, then v2 only, then neither. h1 stays high throughout, so the line lands on the falling edge of v2.
- R6: Every vertical transfer is followed by HSETUP_CYC cycles with h1 high and v1=v2=0 before the first shift.
- R7: Each pixel lasts PIX_CYC cycles, phases 0 to PIX_CYC-1. h1=hl=1 for the first ceil(PIX_CYC/2) phases and 0 for the rest, and h2 is always the inverse of h1. rg is high in phase 0, clamp in phase 1 and sample in the last phase.
- R8: Full-resolution readout reads LINES lines with single transfers. rg, clamp and sample are issued on every pixel. line_start is high for one cycle on phase 0 of pixel 0 of every readout line.
- R9: Binned readout reads LINES/3 lines, each preceded by three back-to-back vertical transfers. rg and clamp are issued only on pixels whose index mod 3 is 0. sample is issued on pixels whose index mod 3 is 2, and on the last pixel of the line.
- R10: frame_end is high for exactly one cycle, directly after the last shift cycle of the last readout line. busy is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request pulse |
| bin_mode | input | 1 | 0 = full resolution, 1 = 3x3 binned |
| int_len | input | INT_W | Exposure length in system cycles |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| hl | output | 1 | Last horizontal phase |
| rg | output | 1 | Output reset gate |
| clamp | output | 1 | ADC reference-level strobe |
| sample | output | 1 | ADC signal-level strobe |
| busy | output | 1 | Frame in progress |
| line_start | output | 1 | First shift cycle of a readout line |
| frame_end | output | 1 | Frame finished |

## Verification
The embedded assertions check, on every cycle, the local ordering rules: v2 rises only while v1 is high and v1 rises only while v2 is low. They also check that v2 falls only with h1 high, that both vertical phases are low during exposure, that rg falls in an h1-high phase, that sample comes after the dump, that clamp directly follows rg, and that a start during a frame never restarts the flush. Line and pixel counts, the exposure length, the binned grouping with its partial final group, the latching of mode and length, and the frame-end timing can only be shown by the bench. It replays whole frames against a cycle-exact expected stream.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FLUSH,
        SQ_INTEG,
        SQ_VXFER,
        SQ_HSETUP,
        SQ_HSHIFT,
        SQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic v1;
        logic v2;
    } vclk_t;

    typedef struct packed {
        logic h1;
        logic h2;
        logic hl;
        logic rg;
        logic clamp;
        logic sample;
    } hclk_t;

    // number of pixel phases with h1 high
    function automatic int h1_high_phases(input int pix_cyc);
        return (pix_cyc + 1) / 2;
    endfunction

endpackage

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen
    import ccd_seq_pkg::*;
#(
    parameter int VHIGH_CYC = 1000,
    parameter int CNT_W     = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] t,
    output vclk_t            vc
);
    localparam logic [CNT_W-1:0] Q1 = CNT_W'(VHIGH_CYC / 4);
    localparam logic [CNT_W-1:0] Q2 = CNT_W'(2 * (VHIGH_CYC / 4));
    localparam logic [CNT_W-1:0] Q3 = CNT_W'(3 * (VHIGH_CYC / 4));

    always_comb begin
        vc.v1 = active && (t < Q2);
        vc.v2 = active && (t >= Q1) && (t < Q3);
    end

    // R5
    v2_rise_in_v1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vc.v2) |-> vc.v1);
    // R5
    v1_rise_v2_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vc.v1) |-> !vc.v2);

endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen
    import ccd_seq_pkg::*;
#(
    parameter int PIX_CYC = 5,
    parameter int PH_W    = 3,
    parameter int GRP_W   = 2,
    parameter int BIN     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             flushing,
    input  logic             binned,
    input  logic [PH_W-1:0]  ph,
    input  logic [GRP_W-1:0] grp,
    input  logic             last_pix,
    output hclk_t            hc
);
    localparam logic [PH_W-1:0]  H1_PH   = PH_W'(h1_high_phases(PIX_CYC));
    localparam logic [PH_W-1:0]  LAST_PH = PH_W'(PIX_CYC - 1);
    localparam logic [GRP_W-1:0] GRP_END = GRP_W'(BIN - 1);

    logic grp_first, grp_close;

    always_comb begin
        grp_first = !binned || (grp == '0);
        grp_close = !binned || (grp == GRP_END) || last_pix;
        hc.h1     = !active || (ph < H1_PH);
        hc.h2     = !hc.h1;
        hc.hl     = hc.h1;
        hc.rg     = active && (ph == '0) && (flushing || grp_first);
        hc.clamp  = active && !flushing && (ph == PH_W'(1)) && grp_first;
        hc.sample = active && !flushing && (ph == LAST_PH) && grp_close;
    end

    // R7
    rg_before_dump_chk: assert property (@(posedge clk) disable iff (rst)
        hc.rg |-> hc.hl);
    // R7
    sample_after_dump_chk: assert property (@(posedge clk) disable iff (rst)
        hc.sample |-> !hc.hl);
    // R9
    clamp_after_rg_chk: assert property (@(posedge clk) disable iff (rst)
        hc.clamp |-> $past(hc.rg));

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
    import ccd_seq_pkg::*;
#(
    parameter int PIX_CYC      = 5,
    parameter int VHIGH_CYC    = 1000,
    parameter int HSETUP_CYC   = 500,
    parameter int PIX_PER_LINE = 1546,
    parameter int LINES        = 1536,
    parameter int BIN          = 3,
    parameter int INT_W        = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bin_mode,
    input  logic [INT_W-1:0] int_len,
    output logic             v1,
    output logic             v2,
    output logic             h1,
    output logic             h2,
    output logic             hl,
    output logic             rg,
    output logic             clamp,
    output logic             sample,
    output logic             busy,
    output logic             line_start,
    output logic             frame_end
);
    localparam int CNT_W = INT_W + 1;
    localparam int PH_W  = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
    localparam int PIX_W = (PIX_PER_LINE > 2) ? $clog2(PIX_PER_LINE) : 1;
    localparam int LN_W  = (LINES > 2) ? $clog2(LINES) : 1;
    localparam int GRP_W = (BIN > 2) ? $clog2(BIN) : 1;
    localparam logic [CNT_W-1:0] V_END  = CNT_W'(VHIGH_CYC - 1);
    localparam logic [CNT_W-1:0] HS_END = CNT_W'(HSETUP_CYC - 1);
    localparam logic [PH_W-1:0]  PH_END = PH_W'(PIX_CYC - 1);
    localparam logic [PIX_W-1:0] PX_END = PIX_W'(PIX_PER_LINE - 1);
    localparam logic [GRP_W-1:0] G_END  = GRP_W'(BIN - 1);
    localparam logic [LN_W-1:0]  FULL_LAST = LN_W'(LINES - 1);
    localparam logic [LN_W-1:0]  BIN_LAST  = LN_W'(LINES / BIN - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  ph;
    logic [PIX_W-1:0] pix;
    logic [GRP_W-1:0] grp;
    logic [GRP_W-1:0] vsub;
    logic [LN_W-1:0]  line;
    logic [INT_W-1:0] int_q;
    logic             bin_q;
    logic             flushing;
    logic [LN_W-1:0]  last_line;
    logic             more_vxfer;
    logic             integ_end;
    vclk_t            vc;
    hclk_t            hc;

    always_comb begin
        last_line  = (flushing || !bin_q) ? FULL_LAST : BIN_LAST;
        more_vxfer = !flushing && bin_q && (vsub != G_END);
        integ_end  = (cnt + CNT_W'(1)) >= {1'b0, int_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            ph       <= '0;
            pix      <= '0;
            grp      <= '0;
            vsub     <= '0;
            line     <= '0;
            int_q    <= '0;
            bin_q    <= 1'b0;
            flushing <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) begin
                    state    <= SQ_FLUSH;
                    bin_q    <= bin_mode;
                    int_q    <= int_len;
                    flushing <= 1'b1;
                    line     <= '0;
                end
                SQ_FLUSH: begin
                    state <= SQ_VXFER;
                    cnt   <= '0;
                    vsub  <= '0;
                end
                SQ_VXFER: begin
                    if (cnt == V_END) begin
                        cnt <= '0;
                        if (more_vxfer) vsub <= vsub + GRP_W'(1);
                        else            state <= SQ_HSETUP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_HSETUP: begin
                    if (cnt == HS_END) begin
                        state <= SQ_HSHIFT;
                        cnt   <= '0;
                        ph    <= '0;
                        pix   <= '0;
                        grp   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_HSHIFT: begin
                    if (ph == PH_END) begin
                        ph <= '0;
                        if (pix == PX_END) begin
                            cnt  <= '0;
                            vsub <= '0;
                            if (line == last_line) begin
                                line <= '0;
                                if (flushing) begin
                                    state    <= SQ_INTEG;
                                    flushing <= 1'b0;
                                end else begin
                                    state <= SQ_DONE;
                                end
                            end else begin
                                line  <= line + LN_W'(1);
                                state <= SQ_VXFER;
                            end
                        end else begin
                            pix <= pix + PIX_W'(1);
                            grp <= (grp == G_END) ? '0 : grp + GRP_W'(1);
                        end
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                SQ_INTEG: begin
                    if (integ_end) begin
                        state <= SQ_VXFER;
                        cnt   <= '0;
                        vsub  <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    ccd_vclk_gen #(
        .VHIGH_CYC (VHIGH_CYC),
        .CNT_W     (CNT_W)
    ) vclk_i (
        .clk    (clk),
        .rst    (rst),
        .active (state == SQ_VXFER),
        .t      (cnt),
        .vc     (vc)
    );

    ccd_hclk_gen #(
        .PIX_CYC (PIX_CYC),
        .PH_W    (PH_W),
        .GRP_W   (GRP_W),
        .BIN     (BIN)
    ) hclk_i (
        .clk      (clk),
        .rst      (rst),
        .active   (state == SQ_HSHIFT),
        .flushing (flushing),
        .binned   (bin_q),
        .ph       (ph),
        .grp      (grp),
        .last_pix (pix == PX_END),
        .hc       (hc)
    );

    always_comb begin
        v1         = vc.v1;
        v2         = vc.v2;
        h1         = hc.h1;
        h2         = hc.h2;
        hl         = hc.hl;
        rg         = hc.rg;
        clamp      = hc.clamp;
        sample     = hc.sample;
        busy       = (state != SQ_IDLE);
        line_start = (state == SQ_HSHIFT) && !flushing && (ph == '0) && (pix == '0);
        frame_end  = (state == SQ_DONE);
    end

    // R4
    integ_vlow_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_INTEG) |-> (!v1 && !v2));
    // R5
    v2_fall_h1_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(v2) |-> h1);
    // R2
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (state != SQ_FLUSH));
    // R10
    end_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !busy);

endmodule

// File: tb/ccd_seq_top_tb_top.sv
module ccd_seq_top_tb_top;
    localparam int PC = 5;
    localparam int VH = 8;
    localparam int HS = 4;
    localparam int NP = 7;
    localparam int NL = 6;
    localparam int IW = 16;
    localparam int QV = VH / 4;
    localparam int H1P = (PC + 1) / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bin = 1'b0;
    logic [IW-1:0] ilen = '0;
    logic v1, v2, h1, h2, hl, rg, clamp, sample, busy, line_start, frame_end;

    int compared = 0;
    int mismatched = 0;
    logic [10:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    ccd_seq_top #(
        .PIX_CYC(PC), .VHIGH_CYC(VH), .HSETUP_CYC(HS),
        .PIX_PER_LINE(NP), .LINES(NL), .BIN(3), .INT_W(IW)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .bin_mode(bin), .int_len(ilen),
        .v1(v1), .v2(v2), .h1(h1), .h2(h2), .hl(hl), .rg(rg), .clamp(clamp),
        .sample(sample), .busy(busy), .line_start(line_start), .frame_end(frame_end)
    );

    wire [10:0] act = {busy, v1, v2, h1, h2, hl, rg, clamp, sample, line_start, frame_end};

    function automatic logic [10:0] mk(bit b, bit a1, bit a2, bit h, bit r,
                                       bit c, bit s, bit l, bit f);
        return {b, a1, a2, h, ~h, h, r, c, s, l, f};
    endfunction

    task automatic push(logic [10:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic check(logic [10:0] e, string t);
        compared++;
        if (act !== e) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", t, act, e);
        end
    endtask

    task automatic add_line(int nv, bit fl, bit bm);
        for (int v = 0; v < nv; v++)
            for (int t = 0; t < VH; t++)
                push(mk(1, t < 2 * QV, (t >= QV) && (t < 3 * QV), 1, 0, 0, 0, 0, 0), "R5");
        for (int s = 0; s < HS; s++)
            push(mk(1, 0, 0, 1, 0, 0, 0, 0, 0), "R6");
        for (int p = 0; p < NP; p++)
            for (int ph = 0; ph < PC; ph++) begin
                bit r, c, s, l;
                r = (ph == 0) && (fl || !bm || (p % 3 == 0));
                c = !fl && (ph == 1) && (!bm || (p % 3 == 0));
                s = !fl && (ph == PC - 1) && (!bm || (p % 3 == 2) || (p == NP - 1));
                l = !fl && (p == 0) && (ph == 0);
                push(mk(1, 0, 0, ph < H1P, r, c, s, l, 0),
                     fl ? "R3" : (bm ? "R9" : "R7 R8"));
            end
    endtask

    task automatic build(bit bm, int il);
        int n;
        push(mk(1, 0, 0, 1, 0, 0, 0, 0, 0), "R2");
        for (int l = 0; l < NL; l++) add_line(1, 1, 0);
        n = (il < 1) ? 1 : il;
        for (int k = 0; k < n; k++) push(mk(1, 0, 0, 1, 0, 0, 0, 0, 0), "R4");
        for (int l = 0; l < (bm ? NL / 3 : NL); l++) add_line(bm ? 3 : 1, 0, bm);
        push(mk(1, 0, 0, 1, 0, 0, 0, 0, 1), "R10");
        push(mk(0, 0, 0, 1, 0, 0, 0, 0, 0), "R10 R1");
    endtask

    task automatic run(bit bm, int il, int poke_at);
        int idx;
        string t;
        @(negedge clk);
        start = 1'b1; bin = bm; ilen = IW'(il);
        build(bm, il);
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        while (exp_q.size() > 0) begin
            t = tag_q.pop_front();
            if (poke_at >= 0 && idx > poke_at) t = {t, " R2"};
            check(exp_q.pop_front(), t);
            if (idx == poke_at) begin
                start = 1'b1; bin = ~bm; ilen = IW'(3);
            end else begin
                start = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
        bin = bm;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mk(0, 0, 0, 1, 0, 0, 0, 0, 0), "R1 reset");
        run(0, 10, -1);
        run(1, 0, 40);
        run(0, 1, 5);
        run(1, 2, -1);
        @(negedge clk);
        check(mk(0, 0, 0, 1, 0, 0, 0, 0, 0), "R1 idle");
        summary();
        $finish;
    end
endmodule